// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block switches a group of clock outputs on and off without ever producing a shortened pulse. It has two kinds of control. The first is an asynchronous, active-low stop request for the whole group. The second is a register of enable bits, one bit per output. The stop request is first brought into the domain of the running source clock through a two-flop synchronizer. A run/stop controller then decides whether the group may switch. Once the group has restarted, the controller refuses to stop it again until a minimum number of clock pulses has been delivered.

Each output passes through its own gate cell. The cell's enable flop changes only on the falling edge of the source clock. An output therefore stops after a complete high phase, stays low, and restarts with a complete high phase. One extra output is free-running: the stop request never reaches it, and only its own enable bit can silence it. Other clock groups on the chip are not connected to this block and keep running while this group is stopped.

Top module: `clk_stop_gate`

## Requirements
- R1: After `stop_n` falls (driven between edges, while the group has run long enough), gated outputs still pulse on the first three rising edges of `clk_src`. From the fourth edge on they carry no pulse.
- R2: While the group is stopped, every gated output is 0 in both the high and the low phase of `clk_src`.
- R3: After `stop_n` rises, gated outputs stay low on the first three rising edges. The first pulse comes on the fourth edge and lasts the whole high phase of `clk_src`.
- R4: The delay from a change of `stop_n` to the effect on the outputs is less than four `clk_src` periods, both for stopping and for restarting.
- R5: Once the group has restarted, it delivers at least MIN_RUN pulses (default 100) before any stop takes effect. Suppose `stop_n` is high for d cycles and then falls. The group then delivers exactly max(MIN_RUN, d) pulses before it parks.
- R6: `clk_free` ignores `stop_n` entirely. It pulses on every rising edge while `free_en` is 1, and it is low while `free_en` is 0.
- R7: Clearing `gate_en[i]` (bit i controls `clk_gated[i]`) holds that output low from the next rising edge on, whatever the state of `stop_n`. Setting the bit while the group runs gives a pulse on the next rising edge.
- R8: Each output follows only its own enable bit. Changing one bit never changes another output.
- R9: While `rst_n` is low, all outputs are 0. After reset, the group starts from the stopped state with the minimum-run count cleared, and `clk_free` pulses from the first edge if `free_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Running internal source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request for the gated group |
| gate_en | input | NUM_GATED | Per-output enable bits, synchronous to `clk_src`; bit i controls `clk_gated[i]` |
| free_en | input | 1 | Enable bit for the free-running output |
| clk_gated | output | NUM_GATED | Gated clock outputs |
| clk_free | output | 1 | Free-running output, unaffected by `stop_n` |

## Verification
The hardest situation to reach is a stop request that arrives while the minimum-run window is still open. The stop must then be held back and released at exactly the right pulse. The bench reaches this by releasing the stop request for a swept number of cycles, from one cycle to past MIN_RUN, and then lowering it again. For each case it counts every gated pulse until the group parks and compares the count with max(MIN_RUN, d). Short releases that fall inside the synchronizer delay are part of the sweep.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Counter width needed to hold the saturation value of a minimum-run count.
  function automatic int unsigned cnt_width(input int unsigned min_run);
    return (min_run > 2) ? $clog2(min_run) : 1;
  endfunction

  // Count value after which a new stop may be accepted:
  // run rises at edge r, stop may fall at edge r+min_run, so limit is min_run-1.
  function automatic int unsigned run_limit(input int unsigned min_run);
    return (min_run > 1) ? min_run - 1 : 0;
  endfunction

  // Next run state: start on a synchronized go, stop only once the window is done.
  function automatic logic run_next(input logic running, input logic go,
                                    input logic held_enough);
    if (running) return go | ~held_enough;
    return go;
  endfunction

  // Number of pulses a release of d cycles produces before the group parks.
  function automatic int unsigned pulses_for_release(input int unsigned d,
                                                     input int unsigned min_run);
    return (d > min_run) ? d : min_run;
  endfunction

endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic run_q,
  output logic held_enough
);
  localparam int unsigned CW    = cnt_width(MIN_RUN);
  localparam int unsigned LIMIT = run_limit(MIN_RUN);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] run_cnt_q;

  assign held_enough = (run_cnt_q == LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      run_cnt_q <= '0;
    end else begin
      run_q <= run_next(run_q, go, held_enough);
      if (!run_q)            run_cnt_q <= '0;
      else if (!held_enough) run_cnt_q <= run_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gate_cell.sv
module gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_d,
  output logic clk_o
);
  logic pass_q;

  // Updated on the falling edge: the enable only moves while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= pass_d;
  end

  assign clk_o = clk & pass_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned NUM_GATED   = 4,
  parameter int unsigned MIN_RUN     = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_src,
  input  logic                 rst_n,
  input  logic                 stop_n,
  input  logic [NUM_GATED-1:0] gate_en,
  input  logic                 free_en,
  output logic [NUM_GATED-1:0] clk_gated,
  output logic                 clk_free
);
  // Named internal events, observed by the bound checker.
  logic sync_go;
  logic run_q;
  logic cnt_done;

  stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .async_in (stop_n),
    .sync_out (sync_go)
  );

  run_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
    .clk         (clk_src),
    .rst_n       (rst_n),
    .go          (sync_go),
    .run_q       (run_q),
    .held_enough (cnt_done)
  );

  for (genvar gi = 0; gi < NUM_GATED; gi++) begin : g_out
    gate_cell u_cell (
      .clk    (clk_src),
      .rst_n  (rst_n),
      .pass_d (run_q & gate_en[gi]),
      .clk_o  (clk_gated[gi])
    );
  end

  gate_cell u_free (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .pass_d (free_en),
    .clk_o  (clk_free)
  );
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned NUM_GATED = 4
) (
  input logic                 clk_src,
  input logic                 rst_n,
  input logic                 sync_go,
  input logic                 run_q,
  input logic                 cnt_done,
  input logic [NUM_GATED-1:0] gate_en,
  input logic                 free_en,
  input logic [NUM_GATED-1:0] clk_gated,
  input logic                 clk_free
);
  AST_STOP_AFTER_SYNC: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(run_q) |-> $past(!sync_go)); // R1

  AST_START_AFTER_SYNC: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(run_q) |-> $past(sync_go)); // R3

  AST_MIN_RUN_HOLD: assert property (@(posedge clk_src) disable iff (!rst_n)
    (run_q && !cnt_done) |=> run_q); // R5

  AST_PARK_LOW: assert property (@(negedge clk_src) disable iff (!rst_n)
    (|clk_gated) |-> $past(run_q)); // R2

  AST_EN_HOLD_LOW: assert property (@(negedge clk_src) disable iff (!rst_n)
    (clk_gated & ~$past(gate_en)) == '0); // R7

  AST_FREE_BY_EN: assert property (@(negedge clk_src) disable iff (!rst_n)
    clk_free |-> $past(free_en)); // R6
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.NUM_GATED(NUM_GATED)) u_chk (
  .clk_src   (clk_src),
  .rst_n     (rst_n),
  .sync_go   (sync_go),
  .run_q     (run_q),
  .cnt_done  (cnt_done),
  .gate_en   (gate_en),
  .free_en   (free_en),
  .clk_gated (clk_gated),
  .clk_free  (clk_free)
);

// File: tb/clk_stop_gate_test.sv
module clk_stop_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG         = 4;
  localparam int MINR       = 100;

  logic          clk_src = 1'b0;
  logic          rst_n;
  logic          stop_n;
  logic [NG-1:0] gate_en;
  logic          free_en;
  logic [NG-1:0] clk_gated;
  logic          clk_free;

  int n_run  = 0;
  int n_fail = 0;

  clk_stop_gate #(.NUM_GATED(NG), .MIN_RUN(MINR)) uut (
    .clk_src   (clk_src),
    .rst_n     (rst_n),
    .stop_n    (stop_n),
    .gate_en   (gate_en),
    .free_en   (free_en),
    .clk_gated (clk_gated),
    .clk_free  (clk_free)
  );

  always #(CLK_PERIOD/2) clk_src = ~clk_src;

  // Wait for a rising edge, land 1 time unit into the high phase (sample point).
  task automatic tick();
    @(posedge clk_src);
    #1;
  endtask

  // Move from the sample point to the drive point, 2 units after the edge.
  task automatic to_drive();
    #1;
  endtask

  task automatic chk(input string req, input logic [NG:0] act, input logic [NG:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NG:0] obs();
    return {clk_free, clk_gated};
  endfunction

  function automatic int expect_pulses(input int d);
    return (d > MINR) ? d : MINR;
  endfunction

  localparam logic [NG:0] ALL_ON   = {1'b1, {NG{1'b1}}};
  localparam logic [NG:0] FREE_ONLY = {1'b1, {NG{1'b0}}};

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    stop_n  = 1'b1;
    gate_en = '1;
    free_en = 1'b1;

    // R9: reset state
    repeat (4) begin
      tick();
      chk("R9 reset high phase", obs(), '0);
    end
    to_drive();
    rst_n = 1'b1;
    tick(); chk("R9 R6 free pulses at first edge", obs(), FREE_ONLY);
    tick(); chk("R3 gated low edge 2", obs(), FREE_ONLY);
    tick(); chk("R3 gated low edge 3", obs(), FREE_ONLY);
    tick(); chk("R3 R4 first pulse edge 4", obs(), ALL_ON);
    #3;     chk("R3 pulse full high phase", obs(), ALL_ON);
    #2;

    repeat (MINR + 10) tick();

    // R1/R4: stop latency
    to_drive();
    stop_n = 1'b0;
    for (int e = 1; e <= 3; e++) begin
      tick(); chk("R1 pulses continue before stop", obs(), ALL_ON);
    end
    tick(); chk("R1 R4 stopped at edge 4", obs(), FREE_ONLY);
    repeat (20) begin
      tick(); chk("R2 R6 parked high phase", obs(), FREE_ONLY);
      #3;     chk("R2 parked late high phase", {1'b0, clk_gated}, '0);
      #3;     chk("R2 parked low phase", {1'b0, clk_gated}, '0);
    end

    // R3/R4: restart
    to_drive();
    stop_n = 1'b1;
    for (int e = 1; e <= 3; e++) begin
      tick(); chk("R3 held low while syncing", obs(), FREE_ONLY);
    end
    tick(); chk("R3 R4 first pulse edge 4", obs(), ALL_ON);
    #3;     chk("R3 full first high phase", obs(), ALL_ON);
    #2;
    repeat (MINR + 10) tick();

    // R5: minimum-run sweep over release lengths
    to_drive();
    stop_n = 1'b0;
    repeat (10) tick();
    foreach (sweep_d[k]) begin
      int pulses;
      int d;
      d = sweep_d[k];
      pulses = 0;
      to_drive();
      stop_n = 1'b1;
      repeat (d) begin
        tick();
        if (clk_gated[0]) pulses++;
      end
      to_drive();
      stop_n = 1'b0;
      repeat (MINR + 12) begin
        tick();
        if (clk_gated[0]) pulses++;
      end
      chk("R5 pulse count after release", pulses[NG:0], expect_pulses(d) & {(NG+1){1'b1}});
      n_run++;
      if (pulses != expect_pulses(d)) begin
        n_fail++;
        $display("FAIL R5 release=%0d actual=%0d expected=%0d", d, pulses, expect_pulses(d));
      end
      chk("R5 R2 parked after window", obs(), FREE_ONLY);
    end

    // R7/R8: enable sweep while running
    to_drive();
    stop_n = 1'b1;
    repeat (MINR + 10) tick();
    for (int m = 0; m < (1 << (NG + 1)); m++) begin
      to_drive();
      {free_en, gate_en} = m[NG:0];
      tick(); chk("R7 R8 enable mask next edge", obs(), m[NG:0]);
      tick(); chk("R7 R8 enable mask steady", obs(), m[NG:0]);
    end

    // R6/R7: enable sweep while stopped
    to_drive();
    {free_en, gate_en} = ALL_ON;
    stop_n = 1'b0;
    repeat (6) tick();
    for (int m = 0; m < (1 << (NG + 1)); m++) begin
      to_drive();
      {free_en, gate_en} = m[NG:0];
      tick(); chk("R6 R7 stopped group ignores enables", obs(), {m[NG], {NG{1'b0}}});
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  int sweep_d [9] = '{1, 2, 3, 4, 60, 99, 100, 101, 140};
endmodule